// File: doc/BRIEF.md
# Register Rename Map with Short-Lived Result Detection

This block keeps the speculative mapping from architectural registers to physical tags in an out-of-order core whose reorder-buffer slots double as physical registers. Each architectural register has an entry that holds a tag and a location bit. The location bit is 1 when the committed value sits in the architectural register file and 0 when the value lives in a reorder-buffer slot. On every dispatch the block looks up both source operands and gives the destination a new tag. The tag is the next reorder-buffer slot index, and a destination gets one even when it names the same register as an earlier instruction.

Ahead of each result writeback the execution side sends a notice that names the result's architectural destination and its tag. If a younger instruction has already remapped that destination, the block flags the result as short-lived. Writeback can then steer the value into a small dedicated register file instead of the main one. The value still has to be kept there, because misprediction recovery and precise exceptions may need it. The block also handles two other events. A commit whose tag still owns its entry moves that entry's location back to the architectural file. A flush returns every entry to its architectural-file mapping.

Top module: `reg_rename_map`

## Requirements
- R1: After reset, entry i holds tag i with location bit 1 (1 = architectural file, 0 = reorder buffer), and `ren_valid` and `sl_valid` are 0.
- R2: Each dispatch with a destination receives `ren_dst_tag` from a slot counter. The counter starts at 0 after reset or flush and advances by one modulo ROB_SLOTS. A dispatch without a destination leaves the counter unchanged.
- R3: Sources are looked up before the same cycle's destination update, so a source that names the instruction's own destination returns the previous mapping.
- R4: Once a dispatch has renamed register d, later source lookups of d return its tag with `in_arf` = 0.
- R5: A check of (dst, tag) raises `sl_flag` = 0 only when the entry for dst holds that tag with location 0. In every other case `sl_flag` = 1. The result appears on `sl_flag` and `sl_valid` in the cycle after the check.
- R6: If a dispatch renames the checked destination in the same cycle as the check, the result is short-lived (`sl_flag` = 1).
- R7: A commit whose tag matches the entry of its destination sets that entry's location to 1 and keeps the tag. A commit with a stale tag leaves the entry unchanged.
- R8: When a commit and a dispatch name the same register in the same cycle, the dispatch's new mapping (location 0) is what remains.
- R9: A flush restores every entry to the reset mapping and sets the slot counter to 0. It also discards the dispatch, commit and check of that cycle, so `ren_valid` and `sl_valid` are 0 in the next cycle.
- R10: All outputs are registered and reflect the inputs of the previous cycle (`ren_valid` follows `disp_valid`, `sl_valid` follows `chk_valid`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Restore all mappings to the architectural file |
| disp_valid | input | 1 | Instruction dispatched this cycle |
| disp_has_dst | input | 1 | Dispatched instruction writes a register |
| disp_dst | input | AW | Architectural destination |
| disp_src_a | input | AW | First architectural source |
| disp_src_b | input | AW | Second architectural source |
| cm_valid | input | 1 | Instruction commits this cycle |
| cm_dst | input | AW | Committing instruction's destination |
| cm_tag | input | TAG_W | Committing instruction's tag |
| chk_valid | input | 1 | Advance notice of a result writeback |
| chk_dst | input | AW | Result's architectural destination |
| chk_tag | input | TAG_W | Result's tag |
| ren_valid | output | 1 | Rename result valid |
| ren_has_dst | output | 1 | Rename result carries a new destination tag |
| ren_dst_tag | output | TAG_W | Allocated destination tag |
| ren_src_a_tag | output | TAG_W | Tag of source A |
| ren_src_a_in_arf | output | 1 | Source A location bit |
| ren_src_b_tag | output | TAG_W | Tag of source B |
| ren_src_b_in_arf | output | 1 | Source B location bit |
| sl_valid | output | 1 | Short-lived decision valid |
| sl_flag | output | 1 | Result is short-lived |

## Verification
A dispatch can rename the very destination that a short-lived check names in the same cycle. A commit can also land on the register that a dispatch overwrites in the same cycle. The bench provokes the first case by checking a tag that still owns its entry while a new dispatch targets that register, and it expects `sl_flag` = 1. It provokes the second case by committing the entry's current tag while a dispatch remaps the same register. A following lookup must then show the new tag in the reorder buffer.

// File: rtl/rnm_pkg.sv
package rnm_pkg;

  // width of a tag able to name both every architectural index and every slot
  function automatic int tag_bits(input int arch_regs, input int rob_slots);
    int span;
    span = (arch_regs > rob_slots) ? arch_regs : rob_slots;
    return (span <= 2) ? 1 : $clog2(span);
  endfunction

  function automatic int idx_bits(input int arch_regs);
    return (arch_regs <= 2) ? 1 : $clog2(arch_regs);
  endfunction

endpackage

// File: rtl/rnm_alloc.sv
module rnm_alloc #(
  parameter int ROB_SLOTS = 16,
  parameter int TAG_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             take,
  output logic [TAG_W-1:0] cur_tag
);
  localparam logic [TAG_W-1:0] LAST_SLOT = TAG_W'(ROB_SLOTS - 1);

  logic [TAG_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      slot_q <= '0;
    end else if (take) begin
      slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
    end
  end

  assign cur_tag = slot_q;
endmodule

// File: rtl/rnm_table.sv
module rnm_table #(
  parameter int ARCH_REGS = 8,
  parameter int TAG_W     = 4,
  parameter int AW        = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             cm_en,
  input  logic [AW-1:0]    cm_idx,
  input  logic [TAG_W-1:0] cm_tag,
  input  logic [AW-1:0]    rd_a_idx,
  input  logic [AW-1:0]    rd_b_idx,
  input  logic [AW-1:0]    rd_c_idx,
  output logic [TAG_W-1:0] rd_a_tag,
  output logic             rd_a_loc,
  output logic [TAG_W-1:0] rd_b_tag,
  output logic             rd_b_loc,
  output logic [TAG_W-1:0] rd_c_tag,
  output logic             rd_c_loc
);
  logic [ARCH_REGS*TAG_W-1:0] tag_flat;
  logic [ARCH_REGS-1:0]       loc_flat;

  for (genvar g = 0; g < ARCH_REGS; g++) begin : g_entry
    logic [TAG_W-1:0] e_tag;
    logic             e_loc;
    logic             hit_wr;
    logic             hit_cm;

    assign hit_wr = wr_en && (wr_idx == AW'(g));
    assign hit_cm = cm_en && (cm_idx == AW'(g)) && !e_loc && (e_tag == cm_tag);

    always_ff @(posedge clk) begin
      if (rst || flush) begin
        e_tag <= TAG_W'(g);
        e_loc <= 1'b1;
      end else if (hit_wr) begin
        e_tag <= wr_tag;
        e_loc <= 1'b0;
      end else if (hit_cm) begin
        e_loc <= 1'b1;
      end
    end

    assign tag_flat[g*TAG_W +: TAG_W] = e_tag;
    assign loc_flat[g]                = e_loc;
  end

  function automatic logic [TAG_W-1:0] pick_tag(input logic [ARCH_REGS*TAG_W-1:0] v,
                                                input logic [AW-1:0] i);
    logic [TAG_W-1:0] r;
    r = '0;
    for (int k = 0; k < ARCH_REGS; k++) begin
      if (i == AW'(k)) r = v[k*TAG_W +: TAG_W];
    end
    return r;
  endfunction

  function automatic logic pick_loc(input logic [ARCH_REGS-1:0] v, input logic [AW-1:0] i);
    logic r;
    r = 1'b1;
    for (int k = 0; k < ARCH_REGS; k++) begin
      if (i == AW'(k)) r = v[k];
    end
    return r;
  endfunction

  always_comb begin
    rd_a_tag = pick_tag(tag_flat, rd_a_idx);
    rd_a_loc = pick_loc(loc_flat, rd_a_idx);
    rd_b_tag = pick_tag(tag_flat, rd_b_idx);
    rd_b_loc = pick_loc(loc_flat, rd_b_idx);
    rd_c_tag = pick_tag(tag_flat, rd_c_idx);
    rd_c_loc = pick_loc(loc_flat, rd_c_idx);
  end
endmodule

// File: rtl/rnm_slchk.sv
module rnm_slchk #(
  parameter int TAG_W = 4
) (
  input  logic             ent_loc,
  input  logic [TAG_W-1:0] ent_tag,
  input  logic [TAG_W-1:0] res_tag,
  input  logic             remap_now,
  output logic             short_lived
);
  // the result still owns its entry only while the entry points at it in the reorder buffer
  logic still_owner;
  assign still_owner = !ent_loc && (ent_tag == res_tag);
  assign short_lived = remap_now || !still_owner;
endmodule

// File: rtl/reg_rename_map.sv
module reg_rename_map #(
  parameter int ARCH_REGS = 8,
  parameter int ROB_SLOTS = 16,
  localparam int TAG_W    = rnm_pkg::tag_bits(ARCH_REGS, ROB_SLOTS),
  localparam int AW       = rnm_pkg::idx_bits(ARCH_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             disp_valid,
  input  logic             disp_has_dst,
  input  logic [AW-1:0]    disp_dst,
  input  logic [AW-1:0]    disp_src_a,
  input  logic [AW-1:0]    disp_src_b,
  input  logic             cm_valid,
  input  logic [AW-1:0]    cm_dst,
  input  logic [TAG_W-1:0] cm_tag,
  input  logic             chk_valid,
  input  logic [AW-1:0]    chk_dst,
  input  logic [TAG_W-1:0] chk_tag,
  output logic             ren_valid,
  output logic             ren_has_dst,
  output logic [TAG_W-1:0] ren_dst_tag,
  output logic [TAG_W-1:0] ren_src_a_tag,
  output logic             ren_src_a_in_arf,
  output logic [TAG_W-1:0] ren_src_b_tag,
  output logic             ren_src_b_in_arf,
  output logic             sl_valid,
  output logic             sl_flag
);
  logic             alloc_now;
  logic [TAG_W-1:0] new_tag;
  logic [TAG_W-1:0] a_tag, b_tag, c_tag;
  logic             a_loc, b_loc, c_loc;
  logic             remap_hit;
  logic             is_short;

  assign alloc_now = disp_valid && disp_has_dst && !flush;
  assign remap_hit = alloc_now && (disp_dst == chk_dst);

  rnm_alloc #(.ROB_SLOTS(ROB_SLOTS), .TAG_W(TAG_W)) u_alloc (
    .clk(clk), .rst(rst), .flush(flush), .take(alloc_now), .cur_tag(new_tag)
  );

  rnm_table #(.ARCH_REGS(ARCH_REGS), .TAG_W(TAG_W), .AW(AW)) u_table (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_en(alloc_now), .wr_idx(disp_dst), .wr_tag(new_tag),
    .cm_en(cm_valid && !flush), .cm_idx(cm_dst), .cm_tag(cm_tag),
    .rd_a_idx(disp_src_a), .rd_b_idx(disp_src_b), .rd_c_idx(chk_dst),
    .rd_a_tag(a_tag), .rd_a_loc(a_loc),
    .rd_b_tag(b_tag), .rd_b_loc(b_loc),
    .rd_c_tag(c_tag), .rd_c_loc(c_loc)
  );

  rnm_slchk #(.TAG_W(TAG_W)) u_slchk (
    .ent_loc(c_loc), .ent_tag(c_tag), .res_tag(chk_tag),
    .remap_now(remap_hit), .short_lived(is_short)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ren_valid        <= 1'b0;
      ren_has_dst      <= 1'b0;
      ren_dst_tag      <= '0;
      ren_src_a_tag    <= '0;
      ren_src_a_in_arf <= 1'b0;
      ren_src_b_tag    <= '0;
      ren_src_b_in_arf <= 1'b0;
      sl_valid         <= 1'b0;
      sl_flag          <= 1'b0;
    end else begin
      ren_valid        <= disp_valid && !flush;
      ren_has_dst      <= alloc_now;
      ren_dst_tag      <= new_tag;
      ren_src_a_tag    <= a_tag;
      ren_src_a_in_arf <= a_loc;
      ren_src_b_tag    <= b_tag;
      ren_src_b_in_arf <= b_loc;
      sl_valid         <= chk_valid && !flush;
      sl_flag          <= chk_valid && !flush && is_short;
    end
  end
endmodule

// File: rtl/reg_rename_map_chk.sv
module reg_rename_map_chk #(
  parameter int ARCH_REGS = 8,
  parameter int ROB_SLOTS = 16,
  localparam int TAG_W    = rnm_pkg::tag_bits(ARCH_REGS, ROB_SLOTS),
  localparam int AW       = rnm_pkg::idx_bits(ARCH_REGS)
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             disp_valid,
  input logic             disp_has_dst,
  input logic [AW-1:0]    disp_dst,
  input logic [AW-1:0]    disp_src_a,
  input logic             chk_valid,
  input logic [AW-1:0]    chk_dst,
  input logic             ren_valid,
  input logic             ren_has_dst,
  input logic [TAG_W-1:0] ren_dst_tag,
  input logic [TAG_W-1:0] ren_src_a_tag,
  input logic             ren_src_a_in_arf,
  input logic             sl_valid,
  input logic             sl_flag
);
  // R1: nothing valid right after reset
  p_idle_after_reset_r1: assert property (@(posedge clk) rst |=> !ren_valid && !sl_valid);

  // R10: rename output follows dispatch one cycle later
  p_ren_follows_disp_r10: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && !flush) |=> ren_valid);

  p_has_dst_needs_valid_r2: assert property (@(posedge clk) disable iff (rst)
    ren_has_dst |-> ren_valid);

  // R4: a source naming the previous destination sees its fresh tag in the reorder buffer
  p_src_sees_prev_dst_r4: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && disp_has_dst && !flush) ##1
    (disp_valid && !flush && disp_src_a == $past(disp_dst))
    |=> (ren_src_a_tag == $past(ren_dst_tag)) && !ren_src_a_in_arf);

  // R6: a same-cycle remap of the checked destination marks the result short-lived
  p_collision_short_r6: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && disp_valid && disp_has_dst && !flush && disp_dst == chk_dst)
    |=> sl_valid && sl_flag);

  // R9: flush drops the cycle's work
  p_flush_drops_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> !ren_valid && !sl_valid);

  // R9: first lookup after a flush reads the architectural file
  p_flush_restores_r9: assert property (@(posedge clk) disable iff (rst)
    (flush ##1 (disp_valid && !flush))
    |=> ren_src_a_in_arf && (ren_src_a_tag == TAG_W'($past(disp_src_a))));

  // R5: the flag is meaningful only with its valid
  p_flag_with_valid_r5: assert property (@(posedge clk) disable iff (rst)
    sl_flag |-> sl_valid);
endmodule

bind reg_rename_map reg_rename_map_chk #(.ARCH_REGS(ARCH_REGS), .ROB_SLOTS(ROB_SLOTS)) u_chk (
  .clk(clk), .rst(rst), .flush(flush),
  .disp_valid(disp_valid), .disp_has_dst(disp_has_dst), .disp_dst(disp_dst),
  .disp_src_a(disp_src_a), .chk_valid(chk_valid), .chk_dst(chk_dst),
  .ren_valid(ren_valid), .ren_has_dst(ren_has_dst), .ren_dst_tag(ren_dst_tag),
  .ren_src_a_tag(ren_src_a_tag), .ren_src_a_in_arf(ren_src_a_in_arf),
  .sl_valid(sl_valid), .sl_flag(sl_flag)
);

// File: tb/test_reg_rename_map.sv
module test_reg_rename_map;
  localparam int NR = 8;
  localparam int NS = 16;
  localparam int TW = 4;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic disp_valid = 1'b0, disp_has_dst = 1'b0;
  logic [AW-1:0] disp_dst = '0, disp_src_a = '0, disp_src_b = '0;
  logic cm_valid = 1'b0;
  logic [AW-1:0] cm_dst = '0;
  logic [TW-1:0] cm_tag = '0;
  logic chk_valid = 1'b0;
  logic [AW-1:0] chk_dst = '0;
  logic [TW-1:0] chk_tag = '0;
  logic ren_valid, ren_has_dst, ren_src_a_in_arf, ren_src_b_in_arf, sl_valid, sl_flag;
  logic [TW-1:0] ren_dst_tag, ren_src_a_tag, ren_src_b_tag;

  always #10 clk = ~clk;

  reg_rename_map #(.ARCH_REGS(NR), .ROB_SLOTS(NS)) i_reg_rename_map (
    .clk(clk), .rst(rst), .flush(flush),
    .disp_valid(disp_valid), .disp_has_dst(disp_has_dst), .disp_dst(disp_dst),
    .disp_src_a(disp_src_a), .disp_src_b(disp_src_b),
    .cm_valid(cm_valid), .cm_dst(cm_dst), .cm_tag(cm_tag),
    .chk_valid(chk_valid), .chk_dst(chk_dst), .chk_tag(chk_tag),
    .ren_valid(ren_valid), .ren_has_dst(ren_has_dst), .ren_dst_tag(ren_dst_tag),
    .ren_src_a_tag(ren_src_a_tag), .ren_src_a_in_arf(ren_src_a_in_arf),
    .ren_src_b_tag(ren_src_b_tag), .ren_src_b_in_arf(ren_src_b_in_arf),
    .sl_valid(sl_valid), .sl_flag(sl_flag)
  );

  int n_tot = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state built from the requirements
  int m_tag [NR];
  bit m_loc [NR];
  int m_ptr;
  int last_tag;

  task automatic model_reset();
    for (int i = 0; i < NR; i++) begin
      m_tag[i] = i;
      m_loc[i] = 1'b1;
    end
    m_ptr = 0;
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tot++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit dv, input bit hd, input int dst, input int sa, input int sb,
                      input bit cv, input int cd, input int ct,
                      input bit wv, input int wd, input int wt,
                      input bit fl, input string req);
    int e_at, e_bt, e_dt;
    bit e_al, e_bl, e_sl;
    e_at = m_tag[sa];
    e_al = m_loc[sa];
    e_bt = m_tag[sb];
    e_bl = m_loc[sb];
    e_dt = m_ptr;
    e_sl = !(m_loc[wd] == 1'b0 && m_tag[wd] == wt) || (dv && hd && dst == wd);
    @(negedge clk);
    disp_valid = dv; disp_has_dst = hd; disp_dst = AW'(dst);
    disp_src_a = AW'(sa); disp_src_b = AW'(sb);
    cm_valid = cv; cm_dst = AW'(cd); cm_tag = TW'(ct);
    chk_valid = wv; chk_dst = AW'(wd); chk_tag = TW'(wt);
    flush = fl;
    if (fl) begin
      model_reset();
    end else begin
      if (cv && m_loc[cd] == 1'b0 && m_tag[cd] == ct) m_loc[cd] = 1'b1;
      if (dv && hd) begin
        m_tag[dst] = m_ptr;
        m_loc[dst] = 1'b0;
        last_tag = m_ptr;
        m_ptr = (m_ptr + 1) % NS;
      end
    end
    @(posedge clk);
    #5;
    check("R10", "ren_valid", int'(ren_valid), int'(dv && !fl));
    check("R10", "sl_valid", int'(sl_valid), int'(wv && !fl));
    if (dv && !fl) begin
      check(req, "src_a_tag", int'(ren_src_a_tag), e_at);
      check(req, "src_a_in_arf", int'(ren_src_a_in_arf), int'(e_al));
      check(req, "src_b_tag", int'(ren_src_b_tag), e_bt);
      check(req, "src_b_in_arf", int'(ren_src_b_in_arf), int'(e_bl));
      check(req, "has_dst", int'(ren_has_dst), int'(hd));
      if (hd) check(req, "dst_tag", int'(ren_dst_tag), e_dt);
    end
    if (wv && !fl) check(req, "sl_flag", int'(sl_flag), int'(e_sl));
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
  endtask

  task automatic rd(input int r, input string req);
    step(1, 0, 0, r, r, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tot++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  end

  initial begin
    int ta;
    model_reset();
    last_tag = 0;
    repeat (3) @(posedge clk);
    #5;
    check("R1", "ren_valid at reset", int'(ren_valid), 0);
    check("R1", "sl_valid at reset", int'(sl_valid), 0);
    @(negedge clk);
    rst = 1'b0;

    // R1: identity mapping in the architectural file
    for (int r = 0; r < NR; r++) step(1, 0, 0, r, NR - 1 - r, 0, 0, 0, 0, 0, 0, 0, "R1");

    // R2 R3 R4: every destination against every source, counter wraps several times
    for (int d = 0; d < NR; d++) begin
      for (int s = 0; s < NR; s++) begin
        step(1, 1, d, d, s, 0, 0, 0, 0, 0, 0, 0, "R3");
        if (s == 3) step(1, 0, 0, s, d, 0, 0, 0, 0, 0, 0, 0, "R2");
      end
    end

    // R5 R6: owner, same-cycle remap, stale tag
    for (int d = 0; d < NR; d++) begin
      step(1, 1, d, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R2");
      ta = last_tag;
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, d, ta, 0, "R5");
      step(1, 1, d, d, 2, 0, 0, 0, 1, d, ta, 0, "R6");
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, d, ta, 0, "R5");
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, d, last_tag, 0, "R5");
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, (d + 1) % NR, last_tag, 0, "R5");
    end

    // R7: matching commit moves the value home; stale commit is ignored
    for (int d = 0; d < NR; d++) begin
      step(1, 1, d, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
      ta = last_tag;
      step(1, 1, d, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
      step(0, 0, 0, 0, 0, 1, d, ta, 0, 0, 0, 0, "R7");
      rd(d, "R7");
      step(0, 0, 0, 0, 0, 1, d, last_tag, 0, 0, 0, 0, "R7");
      rd(d, "R7");
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, d, last_tag, 0, "R5");
    end

    // R8: commit and dispatch on the same register in one cycle
    for (int d = 0; d < NR; d++) begin
      step(1, 1, d, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
      ta = last_tag;
      step(1, 1, d, d, 0, 1, d, ta, 0, 0, 0, 0, "R8");
      rd(d, "R8");
    end

    // R9: flush with every other input active
    step(1, 1, 4, 4, 5, 1, 2, 0, 1, 4, 0, 1, "R9");
    for (int r = 0; r < NR; r++) rd(r, "R9");
    step(1, 1, 5, 5, 1, 0, 0, 0, 0, 0, 0, 0, "R9");
    step(1, 1, 6, 5, 6, 0, 0, 0, 1, 5, 0, 0, "R9");
    idle();

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule